// File: doc/BRIEF.md
# Palette and Border Pixel Colour Stage

This block sits between a frame-buffer fetch path and the video DACs. It takes 32-bit words of packed pixel data and unpacks them at a depth of 1, 2, 4 or 8 bits per pixel, starting from the least significant bits. Each pixel is mapped through a sixteen-entry colour table to a registered 12-bit RGB value and a supremacy flag. A timing block supplies a display-window flag, a border-region flag and a 2-bit cursor code for each pixel. A non-zero cursor code selects one of three cursor colours. Outside the display window the border colour is shown, and outside the border region the output is black.

All colour entries and the depth setting are loaded through a single 32-bit write port. The upper six bits of the written word name the target. The colour or control value sits in the low bits of the same word.

Top module: `pixel_colour_stage`

## Requirements
- R1: On a register write, bits 31:26 of `reg_wdata` select the target: 0 to 15 select a palette entry, 16 selects the border colour, 17, 18 and 19 select cursor colours 1, 2 and 3, and 56 selects the control register. A write with any other selector changes no stored state.
- R2: A colour value is held in bits 12:0 of the written word: red in 3:0, green in 7:4, blue in 11:8 and supremacy in 12. `rgb_out` uses the same red, green and blue layout, and `sup_out` carries the supremacy flag.
- R3: Bits 3:2 of a control write set the depth: 00 is 1 bpp, 01 is 2 bpp, 10 is 4 bpp and 11 is 8 bpp.
- R4: A `word_ld` pulse loads a new 32-bit word. Each `pix_en` cycle consumes the next pixel, taking the least significant unused bits first. When `word_ld` and `pix_en` are both high in one cycle, the pixel comes from the new word.
- R5: At 1, 2 and 4 bpp the pixel value is the palette index.
- R6: At 8 bpp, pixel bits 3:0 index the palette. Pixel bit 4 replaces red bit 3, pixel bits 6:5 replace green bits 3:2, and pixel bit 7 replaces blue bit 3. The supremacy flag comes from the entry.
- R7: A cursor code of 0 is transparent. Codes 1 to 3 output cursor colour 1 to 3, taking priority over the display, border and black cases.
- R8: With cursor code 0, the palette colour is shown when `disp_en` is high, whatever `border_en` is. The border colour is shown when `border_en` is high and `disp_en` is low.
- R9: With cursor code 0 and both flags low, the output is all zero, supremacy included.
- R10: The output register updates only on a `pix_en` cycle, and it shows the result from the next cycle onward. At all other times it holds its value.
- R11: A register write takes effect for pixels in later cycles. A pixel taken in the same cycle as the write uses the old value.
- R12: Reset clears every colour entry, sets the depth to 1 bpp and clears the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Selector in 31:26, value in the low bits |
| word_ld | input | 1 | Load a new packed pixel word |
| word_in | input | 32 | Packed pixel word |
| pix_en | input | 1 | Consume and colour one pixel this cycle |
| disp_en | input | 1 | Pixel is inside the display window |
| border_en | input | 1 | Pixel is inside the border region |
| cursor_pix | input | 2 | Cursor code for this pixel |
| rgb_out | output | 12 | Registered colour: red 3:0, green 7:4, blue 11:8 |
| sup_out | output | 1 | Registered supremacy flag |

## Verification
The colour table is loaded with entries whose red, green and blue fields all differ from one another. Words that mix set and clear bits are then streamed at every depth, so an unpacking order error, a wrong slice width or a wrong index shows up as a wrong colour. At 8 bpp, bytes with varied upper bits separate the pass-through bits from the palette bits. A fixed pixel value is shown under every combination of cursor code and the two region flags, which shows the priority order. Further scenarios cover a write in the same cycle as a pixel, a load in the same cycle as a pixel, writes to unused selectors and idle cycles with changing inputs. These test the timing of updates and that unused selectors and idle cycles leave state untouched.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [1:0] {
    DEPTH_1 = 2'b00,
    DEPTH_2 = 2'b01,
    DEPTH_4 = 2'b10,
    DEPTH_8 = 2'b11
  } depth_e;

  localparam int SEL_W   = 6;
  localparam int CHAN_W  = 4;
  localparam int COL_W   = 3 * CHAN_W;
  localparam int ENT_W   = COL_W + 1;
  localparam int PIX_W   = 8;
  localparam int N_CURS  = 3;

  localparam logic [SEL_W-1:0] SEL_BORDER  = 6'd16;
  localparam logic [SEL_W-1:0] SEL_CURSOR1 = 6'd17;
  localparam logic [SEL_W-1:0] SEL_CONTROL = 6'd56;

  typedef logic [ENT_W-1:0] entry_t;
endpackage

// File: rtl/pcs_regfile.sv
module pcs_regfile
  import pcs_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int PAL_N  = 16,
  localparam int IDX_W = $clog2(PAL_N)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [WORD_W-1:0]       wr_data,
  input  logic [IDX_W-1:0]        rd_idx,
  output entry_t                  rd_entry,
  output entry_t                  border_col,
  output entry_t [N_CURS-1:0]     cursor_col,
  output depth_e                  depth
);
  logic [SEL_W-1:0] sel;
  assign sel = wr_data[WORD_W-1 -: SEL_W];

  entry_t                pal_mem [PAL_N];
  entry_t                border_q;
  entry_t [N_CURS-1:0]   cur_q;
  depth_e                depth_q;

  logic unused_bits;
  assign unused_bits = ^wr_data[WORD_W-SEL_W-1:ENT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PAL_N; i++) pal_mem[i] <= '0;
      border_q <= '0;
      cur_q    <= '0;
      depth_q  <= DEPTH_1;
    end else if (wr_en) begin
      if (int'(sel) < PAL_N) begin
        pal_mem[sel[IDX_W-1:0]] <= wr_data[ENT_W-1:0];
      end else begin
        case (sel)
          SEL_BORDER:         border_q <= wr_data[ENT_W-1:0];
          SEL_CURSOR1:        cur_q[0] <= wr_data[ENT_W-1:0];
          SEL_CURSOR1 + 6'd1: cur_q[1] <= wr_data[ENT_W-1:0];
          SEL_CURSOR1 + 6'd2: cur_q[2] <= wr_data[ENT_W-1:0];
          SEL_CONTROL:        depth_q  <= depth_e'(wr_data[3:2]);
          default: ;
        endcase
      end
    end
  end

  assign rd_entry   = pal_mem[rd_idx];
  assign border_col = border_q;
  assign cursor_col = cur_q;
  assign depth      = depth_q;

  logic sel_known;
  assign sel_known = (int'(sel) < PAL_N) || (sel == SEL_BORDER) || (sel == SEL_CONTROL) ||
                     (sel >= SEL_CURSOR1 && sel <= SEL_CURSOR1 + 6'd2);

  assert_pal_write_R1: assert property (@(posedge clk) disable iff (rst)
    wr_en && int'(sel) < PAL_N |=> pal_mem[$past(sel[IDX_W-1:0])] == $past(wr_data[ENT_W-1:0]));

  assert_unused_sel_R1: assert property (@(posedge clk) disable iff (rst)
    wr_en && !sel_known |=> $stable(border_q) && $stable(cur_q) && $stable(depth_q));

  assert_depth_write_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en && sel == SEL_CONTROL |=> depth_q == $past(wr_data[3:2]));
endmodule

// File: rtl/pcs_unpacker.sv
module pcs_unpacker
  import pcs_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_ld,
  input  logic [WORD_W-1:0] word_in,
  input  logic              pix_en,
  input  depth_e            depth,
  output logic [PIX_W-1:0]  pix
);
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] cur_w;
  logic [PIX_W-1:0]  pick   [4];
  logic [WORD_W-1:0] next_w [4];

  assign cur_w = word_ld ? word_in : sh_q;

  for (genvar g = 0; g < 4; g++) begin : g_depth
    localparam int BPP = 1 << g;
    assign pick[g]   = PIX_W'(cur_w[BPP-1:0]);
    assign next_w[g] = cur_w >> BPP;
  end

  assign pix = pick[depth];

  always_ff @(posedge clk) begin
    if (rst)          sh_q <= '0;
    else if (pix_en)  sh_q <= next_w[depth];
    else if (word_ld) sh_q <= word_in;
  end

  assert_load_R4: assert property (@(posedge clk) disable iff (rst)
    word_ld && !pix_en |=> sh_q == $past(word_in));

  assert_shift8_R4: assert property (@(posedge clk) disable iff (rst)
    pix_en && !word_ld && depth == DEPTH_8 |=> sh_q == {8'h00, $past(sh_q[WORD_W-1:8])});
endmodule

// File: rtl/pcs_colour_sel.sv
module pcs_colour_sel
  import pcs_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                pix_en,
  input  logic [PIX_W-1:0]    pix,
  input  depth_e              depth,
  input  logic                disp_en,
  input  logic                border_en,
  input  logic [1:0]          cursor,
  input  entry_t              pal_entry,
  input  entry_t              border_col,
  input  entry_t [N_CURS-1:0] cursor_col,
  output logic [COL_W-1:0]    rgb,
  output logic                sup
);
  entry_t base, chosen, out_q;

  logic unused_low;
  assign unused_low = ^pix[3:0];

  always_comb begin
    base = pal_entry;
    if (depth == DEPTH_8) begin
      base[CHAN_W-1]          = pix[4];
      base[2*CHAN_W-1 -: 2]   = pix[6:5];
      base[3*CHAN_W-1]        = pix[7];
    end
    if (cursor != 2'd0)  chosen = cursor_col[2'(cursor - 2'd1)];
    else if (disp_en)    chosen = base;
    else if (border_en)  chosen = border_col;
    else                 chosen = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)         out_q <= '0;
    else if (pix_en) out_q <= chosen;
  end

  assign rgb = out_q[COL_W-1:0];
  assign sup = out_q[ENT_W-1];

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> $stable(out_q));

  assert_black_R9: assert property (@(posedge clk) disable iff (rst)
    pix_en && !disp_en && !border_en && cursor == 2'd0 |=> out_q == '0);

  assert_cursor_R7: assert property (@(posedge clk) disable iff (rst)
    pix_en && cursor != 2'd0 |=> out_q == $past(cursor_col[2'(cursor - 2'd1)]));

  assert_border_R8: assert property (@(posedge clk) disable iff (rst)
    pix_en && !disp_en && border_en && cursor == 2'd0 |=> out_q == $past(border_col));
endmodule

// File: rtl/pixel_colour_stage.sv
module pixel_colour_stage
  import pcs_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int PAL_N  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              word_ld,
  input  logic [WORD_W-1:0] word_in,
  input  logic              pix_en,
  input  logic              disp_en,
  input  logic              border_en,
  input  logic [1:0]        cursor_pix,
  output logic [COL_W-1:0]  rgb_out,
  output logic              sup_out
);
  localparam int IDX_W = $clog2(PAL_N);

  depth_e              depth;
  logic [PIX_W-1:0]    pix;
  entry_t              pal_entry;
  entry_t              border_col;
  entry_t [N_CURS-1:0] cursor_col;

  pcs_regfile #(.WORD_W(WORD_W), .PAL_N(PAL_N)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (reg_wr),
    .wr_data    (reg_wdata),
    .rd_idx     (pix[IDX_W-1:0]),
    .rd_entry   (pal_entry),
    .border_col (border_col),
    .cursor_col (cursor_col),
    .depth      (depth)
  );

  pcs_unpacker #(.WORD_W(WORD_W)) u_unpack (
    .clk     (clk),
    .rst     (rst),
    .word_ld (word_ld),
    .word_in (word_in),
    .pix_en  (pix_en),
    .depth   (depth),
    .pix     (pix)
  );

  pcs_colour_sel u_sel (
    .clk        (clk),
    .rst        (rst),
    .pix_en     (pix_en),
    .pix        (pix),
    .depth      (depth),
    .disp_en    (disp_en),
    .border_en  (border_en),
    .cursor     (cursor_pix),
    .pal_entry  (pal_entry),
    .border_col (border_col),
    .cursor_col (cursor_col),
    .rgb        (rgb_out),
    .sup        (sup_out)
  );
endmodule

// File: tb/pixel_colour_stage_test.sv
module pixel_colour_stage_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        word_ld = 1'b0;
  logic [31:0] word_in = '0;
  logic        pix_en = 1'b0;
  logic        disp_en = 1'b0;
  logic        border_en = 1'b0;
  logic [1:0]  cursor_pix = '0;
  logic [11:0] rgb_out;
  logic        sup_out;

  int checks = 0;
  int failures = 0;

  logic [12:0] mpal [16];
  logic [12:0] mcur [4];
  logic [12:0] mborder;
  int          mbpp;

  always #4 clk = ~clk;

  pixel_colour_stage uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .word_ld(word_ld), .word_in(word_in), .pix_en(pix_en),
    .disp_en(disp_en), .border_en(border_en), .cursor_pix(cursor_pix),
    .rgb_out(rgb_out), .sup_out(sup_out)
  );

  task automatic chk(string req, logic [12:0] act, logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] expv(logic [7:0] p, bit d, bit b, logic [1:0] c);
    logic [12:0] e;
    if (c != 2'd0) return mcur[c];
    if (d) begin
      e = mpal[p[3:0]];
      if (mbpp == 8) begin
        e[3] = p[4]; e[7:6] = p[6:5]; e[11] = p[7];
      end
      return e;
    end
    if (b) return mborder;
    return 13'h0;
  endfunction

  // all tasks start and end just after a falling edge
  task automatic wr(logic [31:0] w);
    reg_wr = 1'b1; reg_wdata = w;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_depth(int bpp);
    logic [1:0] code;
    code = (bpp == 1) ? 2'b00 : (bpp == 2) ? 2'b01 : (bpp == 4) ? 2'b10 : 2'b11;
    wr(32'hE000_0000 | {28'h0, code, 2'b00});
    mbpp = bpp;
  endtask

  task automatic load(logic [31:0] w);
    word_ld = 1'b1; word_in = w;
    @(negedge clk);
    word_ld = 1'b0;
  endtask

  task automatic pix(bit d, bit b, logic [1:0] c, string req, logic [12:0] exp);
    pix_en = 1'b1; disp_en = d; border_en = b; cursor_pix = c;
    @(negedge clk);
    pix_en = 1'b0;
    chk(req, {sup_out, rgb_out}, exp);
  endtask

  task automatic run_word(logic [31:0] w, string req);
    load(w);
    for (int k = 0; k < 32 / mbpp; k++) begin
      logic [31:0] sh;
      logic [7:0]  p;
      sh = w >> (k * mbpp);
      p  = 8'(sh & ((32'd1 << mbpp) - 1));
      pix(1'b1, 1'b0, 2'd0, req, expv(p, 1'b1, 1'b0, 2'd0));
    end
  endtask

  task automatic t_reset;
    chk("R12 output after reset", {sup_out, rgb_out}, 13'h0);
    load(32'hFFFF_FFFF);
    pix(1'b1, 1'b0, 2'd0, "R12 cleared palette", 13'h0);
    pix(1'b0, 1'b1, 2'd0, "R12 cleared border", 13'h0);
    pix(1'b0, 1'b0, 2'd3, "R12 cleared cursor", 13'h0);
  endtask

  task automatic t_load_all;
    for (int n = 0; n < 16; n++) begin
      logic [3:0] v;
      v = 4'(n);
      mpal[n] = {v[0], v ^ 4'h9, ~v, v};
      wr({6'(n), 13'h0, mpal[n]});
    end
    mborder = 13'h1ABC; wr(32'h4000_0000 | 32'(mborder));
    mcur[1] = 13'h0123; wr(32'h4400_0000 | 32'(mcur[1]));
    mcur[2] = 13'h1456; wr(32'h4800_0000 | 32'(mcur[2]));
    mcur[3] = 13'h0789; wr(32'h4C00_0000 | 32'(mcur[3]));
  endtask

  task automatic t_depths;
    run_word(32'hA5C3_0F96, "R12 R4 R5 default 1bpp");
    set_depth(2); run_word(32'h1B6E_D4C9, "R3 R5 2bpp");
    set_depth(4); run_word(32'h7F3A_9C15, "R2 R3 R5 4bpp");
    set_depth(8); run_word(32'h9D6B_F2A7, "R3 R6 8bpp");
  endtask

  task automatic t_overlay;
    set_depth(4);
    load(32'h5555_5555);
    pix(1'b1, 1'b0, 2'd1, "R7 cursor1 over display", mcur[1]);
    pix(1'b1, 1'b1, 2'd2, "R7 cursor2 over display", mcur[2]);
    pix(1'b0, 1'b1, 2'd3, "R7 cursor3 over border", mcur[3]);
    pix(1'b0, 1'b0, 2'd2, "R7 cursor2 over black", mcur[2]);
    pix(1'b0, 1'b1, 2'd0, "R8 border only", mborder);
    pix(1'b1, 1'b1, 2'd0, "R8 display beats border", mpal[5]);
    pix(1'b0, 1'b0, 2'd0, "R9 black", 13'h0);
    pix(1'b1, 1'b0, 2'd0, "R7 code0 transparent", mpal[5]);
  endtask

  task automatic t_hold;
    logic [12:0] held;
    set_depth(4);
    load(32'h0000_000E);
    pix(1'b1, 1'b0, 2'd0, "R10 pixel", mpal[14]);
    held = mpal[14];
    disp_en = 1'b0; border_en = 1'b1; cursor_pix = 2'd1; load(32'h1111_1111);
    chk("R10 hold during load", {sup_out, rgb_out}, held);
    cursor_pix = 2'd0;
    wr(32'h3800_0000 | 32'h0FFF);
    mpal[14] = 13'h0FFF;
    chk("R10 hold during write", {sup_out, rgb_out}, held);
    @(negedge clk);
    chk("R10 hold idle", {sup_out, rgb_out}, held);
  endtask

  task automatic t_same_cycle_write;
    set_depth(4);
    load(32'h0000_0033);
    reg_wr = 1'b1; reg_wdata = 32'h0C00_1E2D;
    pix_en = 1'b1; disp_en = 1'b1; border_en = 1'b0; cursor_pix = 2'd0;
    @(negedge clk);
    reg_wr = 1'b0; pix_en = 1'b0;
    chk("R11 old value same cycle", {sup_out, rgb_out}, mpal[3]);
    mpal[3] = 13'h1E2D;
    pix(1'b1, 1'b0, 2'd0, "R11 new value next pixel", mpal[3]);
  endtask

  task automatic t_ld_and_pix;
    set_depth(4);
    load(32'h0000_0000);
    word_ld = 1'b1; word_in = 32'h0000_00C7;
    pix_en = 1'b1; disp_en = 1'b1; border_en = 1'b0; cursor_pix = 2'd0;
    @(negedge clk);
    word_ld = 1'b0; pix_en = 1'b0;
    chk("R4 load with pixel uses new word", {sup_out, rgb_out}, mpal[7]);
    pix(1'b1, 1'b0, 2'd0, "R4 second pixel", mpal[12]);
  endtask

  task automatic t_ignored;
    set_depth(4);
    wr(32'h5000_1FFF);
    wr(32'hFC00_1FFF);
    wr(32'hE400_000C);
    wr(32'h7C00_1FFF);
    run_word(32'hFEDC_BA98, "R1 palette and depth untouched");
    load(32'h0);
    pix(1'b0, 1'b1, 2'd0, "R1 border untouched", mborder);
    pix(1'b0, 1'b0, 2'd1, "R1 cursor1 untouched", mcur[1]);
    pix(1'b0, 1'b0, 2'd3, "R1 cursor3 untouched", mcur[3]);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mpal[i] = '0;
    for (int i = 0; i < 4; i++) mcur[i] = '0;
    mborder = '0;
    mbpp = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_load_all;
    t_depths;
    t_overlay;
    t_hold;
    t_same_cycle_write;
    t_ld_and_pix;
    t_ignored;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule